// File: doc/BRIEF.md
# Three-Level Nested Interrupt Priority Controller

This block gathers fourteen interrupt request sources onto nine vectors and decides which vector, if any, the processor should service next. Each source has a sticky request flag. A vector requests service when it is enabled and at least one of its sources has its flag set. Five of the vectors are shared by two sources each, and the other four have a single source. Each vector has one priority bit. For the two dedicated external vectors (0 and 1), that bit chooses between low and highest. For the other seven vectors it chooses between low and high.

The block keeps a small in-service record with one bit per level, so routines can nest up to three deep. The pending winner is offered on a valid/ready pair. An offer is only made when the winner's level is strictly above the highest level now in service. The processor takes the vector by asserting ready. That acceptance pulses a one-hot acknowledge, clears the flag of a single-source vector, and records the level as in service. A return strobe retires the highest level in service. The processor pipeline and context stacking lie outside the block.

Back-pressure rules for the vector offer:
- While `irq_valid` is high and `irq_ready` is low, nothing is acknowledged and the in-service record does not change.
- The offer itself is re-evaluated every cycle. It may switch to a stronger winner, or drop, before it is accepted.
- Only the offer present in the cycle where valid and ready are both high is acted on.

Top module: `irq_nest_ctrl`

## Requirements
- R1: Source flag i sets in the cycle after `src_set[i]` is high and stays set until it is cleared. A `src_clr[i]` pulse clears it in the next cycle, but a set in the same cycle wins over the clear. Vector ownership of sources is as follows:
  - vector 0 owns source 0, and vector 1 owns source 1;
  - vector 2 owns sources 2 and 3, and vector 3 owns sources 4 and 5;
  - vector 4 owns source 6, and vector 5 owns sources 7 and 8;
  - vector 6 owns source 9, and vector 7 owns sources 10 and 11;
  - vector 8 owns sources 12 and 13.
- R2: Accepting a single-source vector clears that source's flag in the next cycle. Accepting a shared vector leaves both of its source flags unchanged.
- R3: A vector requests service only if its `vec_en` bit is 1 and one of its source flags is set. A disabled vector is never offered, and its flags are kept.
- R4: The level codes are 1 for low, 2 for high and 3 for highest. A vector whose `vec_pri` bit is 0 has level 1. With `vec_pri` at 1, vectors 0 and 1 have level 3 and vectors 2 to 8 have level 2. `irq_level` shows the offered level, or 0 when there is no offer.
- R5: Among the requesting vectors, the highest level wins. Between vectors at equal level, the lower vector number wins. `irq_vec` is 0 when there is no offer.
- R6: `irq_valid` is high exactly when the winning level is strictly greater than `svc_level`.
- R7: When `irq_valid` and `irq_ready` are both high, `ack_vec` has exactly the bit of `irq_vec` set in that same cycle. In the next cycle `svc_level` equals the accepted level. At all other times `ack_vec` is 0.
- R8: A `reti` pulse removes the highest level in service, and `svc_level` drops to the next level still recorded, or to 0. With nothing in service, `reti` has no effect.
- R9: While `irq_valid` is high and `irq_ready` is low, `svc_level` and `ack_vec` do not change because of the pending offer.
- R10: During reset and in the first cycle after it, every flag is clear, `svc_level` is 0 and `irq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_set | input | 14 | Per-source request pulses |
| src_clr | input | 14 | Per-source flag clear from software |
| src_flag | output | 14 | Per-source request flags |
| vec_en | input | 9 | Per-vector enable |
| vec_pri | input | 9 | Per-vector priority bit |
| irq_valid | output | 1 | A vector is offered for service |
| irq_ready | input | 1 | Processor takes the offered vector |
| irq_vec | output | 4 | Offered vector number |
| irq_level | output | 2 | Offered level code |
| ack_vec | output | 9 | One-hot acknowledge in the accept cycle |
| reti | input | 1 | Return-from-interrupt strobe |
| svc_level | output | 2 | Highest level currently in service |

## Verification
The assertions check the following properties on every cycle:
- set flags persist;
- shared-vector flags survive an acceptance;
- single-source flags clear after an acceptance;
- an offered vector is enabled and requesting, and its level is strictly above the in-service level;
- an acceptance makes the accepted level the one in service;
- a return lowers the in-service level or leaves an empty record empty;
- a stalled offer leaves the in-service level alone.

Only the bench scenarios, compared against a reference model, can show that arbitration picks the right vector, including the tie-break and the asymmetric highest level of vectors 0 and 1. The same applies to nesting order across several pushes and pops, and to set winning over clear in the same cycle.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

  localparam logic [1:0] LVL_NONE = 2'd0;
  localparam logic [1:0] LVL_LOW  = 2'd1;
  localparam logic [1:0] LVL_HIGH = 2'd2;
  localparam logic [1:0] LVL_TOP  = 2'd3;

  // Number of set bits in mask below position idx.
  function automatic int ones_below(input logic [31:0] mask, input int idx);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      if (i < idx && mask[i]) n++;
    end
    return n;
  endfunction

  // Level of vector v given its priority bit.
  function automatic logic [1:0] vec_level(input int v, input int top_vecs, input logic pri);
    if (!pri) return LVL_LOW;
    return (v < top_vecs) ? LVL_TOP : LVL_HIGH;
  endfunction

endpackage

// File: rtl/irq_src_flags.sv
module irq_src_flags
  import irq_nest_pkg::*;
#(
  parameter int                 NUM_VEC     = 9,
  parameter logic [NUM_VEC-1:0] SHARED_MASK = 9'b110101100,
  parameter int                 NUM_SRC     = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_set,
  input  logic [NUM_SRC-1:0] src_clr,
  input  logic [NUM_VEC-1:0] ack_vec,
  input  logic [NUM_VEC-1:0] vec_en,
  output logic [NUM_SRC-1:0] src_flag,
  output logic [NUM_VEC-1:0] vec_req
);

  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] ack_clr;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    localparam int BASE = v + ones_below(32'(SHARED_MASK), v);
    if (SHARED_MASK[v]) begin : g_pair
      assign ack_clr[BASE+1:BASE] = 2'b00;
      assign vec_req[v] = vec_en[v] & (flag_q[BASE] | flag_q[BASE+1]);

      // R2
      pair_lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[BASE] && !src_clr[BASE]) |=> flag_q[BASE]);
      // R2
      pair_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[BASE+1] && !src_clr[BASE+1]) |=> flag_q[BASE+1]);
    end else begin : g_single
      assign ack_clr[BASE] = ack_vec[v];
      assign vec_req[v] = vec_en[v] & flag_q[BASE];

      // R2
      single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vec[v] && !src_set[BASE]) |=> !flag_q[BASE]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~src_clr & ~ack_clr) | src_set;
  end

  assign src_flag = flag_q;

  // R1
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_set) |=> ((src_flag & $past(src_set)) == $past(src_set)));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_nest_pkg::*;
#(
  parameter int NUM_VEC  = 9,
  parameter int TOP_VECS = 2,
  parameter int VEC_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] vec_req,
  input  logic [NUM_VEC-1:0] vec_pri,
  input  logic [1:0]         svc_level,
  output logic               offer_valid,
  output logic [VEC_W-1:0]   offer_vec,
  output logic [1:0]         offer_level
);

  logic [1:0]       best_lvl;
  logic [1:0]       cand_lvl;
  logic [VEC_W-1:0] best_vec;

  // Scan from the top vector down; >= lets a lower number take a tie.
  always_comb begin
    best_lvl = LVL_NONE;
    best_vec = '0;
    cand_lvl = LVL_NONE;
    for (int v = NUM_VEC - 1; v >= 0; v--) begin
      cand_lvl = vec_level(v, TOP_VECS, vec_pri[v]);
      if (vec_req[v] && cand_lvl >= best_lvl) begin
        best_lvl = cand_lvl;
        best_vec = VEC_W'(v);
      end
    end
  end

  assign offer_valid = (best_lvl != LVL_NONE) && (best_lvl > svc_level);
  assign offer_vec   = offer_valid ? best_vec : '0;
  assign offer_level = offer_valid ? best_lvl : LVL_NONE;

  // R3
  offer_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> vec_req[offer_vec]);

endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack
  import irq_nest_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [1:0] push_level,
  input  logic       pop,
  output logic [1:0] svc_level
);

  logic [2:0] act_q, act_d;
  logic [1:0] top;

  always_comb begin
    if      (act_q[2]) top = LVL_TOP;
    else if (act_q[1]) top = LVL_HIGH;
    else if (act_q[0]) top = LVL_LOW;
    else               top = LVL_NONE;
  end

  always_comb begin
    act_d = act_q;
    if (pop && top != LVL_NONE)         act_d[top - 2'd1] = 1'b0;
    if (push && push_level != LVL_NONE) act_d[push_level - 2'd1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  assign svc_level = top;

  // R7
  push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (svc_level == $past(push_level)));
  // R8
  pop_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && svc_level != LVL_NONE) |=> (svc_level < $past(svc_level)));
  // R8
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && svc_level == LVL_NONE) |=> (svc_level == LVL_NONE));

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int                 NUM_VEC     = 9,
  parameter logic [NUM_VEC-1:0] SHARED_MASK = 9'b110101100,
  parameter int                 TOP_VECS    = 2,
  localparam int                NUM_SRC     = NUM_VEC + ones_below(32'(SHARED_MASK), NUM_VEC),
  localparam int                VEC_W       = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_set,
  input  logic [NUM_SRC-1:0] src_clr,
  output logic [NUM_SRC-1:0] src_flag,
  input  logic [NUM_VEC-1:0] vec_en,
  input  logic [NUM_VEC-1:0] vec_pri,
  output logic               irq_valid,
  input  logic               irq_ready,
  output logic [VEC_W-1:0]   irq_vec,
  output logic [1:0]         irq_level,
  output logic [NUM_VEC-1:0] ack_vec,
  input  logic               reti,
  output logic [1:0]         svc_level
);

  logic [NUM_VEC-1:0] vec_req;
  logic               accept;

  assign accept  = irq_valid & irq_ready;
  assign ack_vec = accept ? (NUM_VEC'(1) << irq_vec) : '0;

  irq_src_flags #(
    .NUM_VEC    (NUM_VEC),
    .SHARED_MASK(SHARED_MASK),
    .NUM_SRC    (NUM_SRC)
  ) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_set (src_set),
    .src_clr (src_clr),
    .ack_vec (ack_vec),
    .vec_en  (vec_en),
    .src_flag(src_flag),
    .vec_req (vec_req)
  );

  irq_arbiter #(
    .NUM_VEC (NUM_VEC),
    .TOP_VECS(TOP_VECS),
    .VEC_W   (VEC_W)
  ) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .vec_req    (vec_req),
    .vec_pri    (vec_pri),
    .svc_level  (svc_level),
    .offer_valid(irq_valid),
    .offer_vec  (irq_vec),
    .offer_level(irq_level)
  );

  irq_nest_stack u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .push_level(irq_level),
    .pop       (reti),
    .svc_level (svc_level)
  );

  // R6
  above_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_level > svc_level));
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready && !reti) |=> (svc_level == $past(svc_level)));
  // R7
  ack_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_vec) && ((ack_vec != '0) == (irq_valid && irq_ready)));

endmodule

// File: tb/irq_nest_ctrl_tb.sv
module irq_nest_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] src_set = '0, src_clr = '0, src_flag;
  logic [8:0]  vec_en = '0, vec_pri = '0, ack_vec;
  logic        irq_valid, irq_ready = 1'b0, reti = 1'b0;
  logic [3:0]  irq_vec;
  logic [1:0]  irq_level, svc_level;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state
  logic [13:0] m_flag = '0;
  logic [2:0]  m_act = '0;
  int          base[9] = '{0, 1, 2, 4, 6, 7, 9, 10, 12};
  bit          sh[9]   = '{0, 0, 1, 1, 0, 1, 0, 1, 1};

  localparam logic [8:0] EN = 9'h1FF;

  always #4 clk = ~clk;

  irq_nest_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
    .src_flag(src_flag), .vec_en(vec_en), .vec_pri(vec_pri),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_vec(irq_vec),
    .irq_level(irq_level), .ack_vec(ack_vec), .reti(reti), .svc_level(svc_level)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lvl_of(input int v, input logic pri);
    if (!pri) return 1;
    return (v < 2) ? 3 : 2;
  endfunction

  task automatic step(input logic [13:0] s, input logic [13:0] c, input logic [8:0] e,
                      input logic [8:0] p, input logic r, input logic t);
    int bl, bv, top;
    bit ev;
    logic [8:0]  eack;
    logic [13:0] ackclr;
    @(negedge clk);
    src_set = s; src_clr = c; vec_en = e; vec_pri = p; irq_ready = r; reti = t;
    #1;
    top = m_act[2] ? 3 : m_act[1] ? 2 : m_act[0] ? 1 : 0;
    bl = 0; bv = 0;
    for (int v = 8; v >= 0; v--) begin
      if (e[v] && (m_flag[base[v]] || (sh[v] && m_flag[base[v]+1]))) begin
        int l;
        l = lvl_of(v, p[v]);
        if (l >= bl) begin bl = l; bv = v; end
      end
    end
    ev = (bl > top);
    eack = (ev && r) ? (9'd1 << bv) : 9'd0;
    chk(irq_valid == ev, "R6 offer valid", int'(irq_valid), int'(ev));
    chk(int'(irq_vec) == (ev ? bv : 0), "R5 offered vector", int'(irq_vec), ev ? bv : 0);
    chk(int'(irq_level) == (ev ? bl : 0), "R4 offered level", int'(irq_level), ev ? bl : 0);
    chk(ack_vec == eack, "R7 acknowledge", int'(ack_vec), int'(eack));
    chk(src_flag == m_flag, "R1 R2 R3 flags", int'(src_flag), int'(m_flag));
    chk(int'(svc_level) == top, "R8 R9 in-service level", int'(svc_level), top);
    ackclr = '0;
    if (ev && r && !sh[bv]) ackclr[base[bv]] = 1'b1;
    m_flag = (m_flag & ~c & ~ackclr) | s;
    if (t && top > 0) m_act[top-1] = 1'b0;
    if (ev && r) m_act[bl-1] = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] r_en, r_pri;
    logic [13:0] s, c;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(irq_valid == 1'b0, "R10 valid in reset", int'(irq_valid), 0);
    chk(src_flag == '0, "R10 flags in reset", int'(src_flag), 0);
    chk(svc_level == 2'd0, "R10 svc in reset", int'(svc_level), 0);
    rst_n = 1'b1;

    step(14'h0044, '0, EN, '0, 0, 0);
    step('0, '0, EN, '0, 0, 0);
    chk(irq_vec == 4'd2, "R5 tie goes to lower vector", int'(irq_vec), 2);
    step('0, '0, EN, 9'h010, 0, 0);
    chk(irq_vec == 4'd4 && irq_level == 2'd2, "R4 high beats low", int'(irq_vec), 4);
    step('0, '0, EN, 9'h010, 1, 0);
    chk(ack_vec == 9'h010, "R7 ack one-hot", int'(ack_vec), 16);
    step('0, '0, EN, 9'h010, 0, 0);
    chk(svc_level == 2'd2, "R7 level pushed", int'(svc_level), 2);
    chk(irq_valid == 1'b0, "R6 low blocked under high", int'(irq_valid), 0);
    chk(src_flag[6] == 1'b0, "R2 single-source cleared", int'(src_flag[6]), 0);
    step(14'h0001, '0, EN, 9'h011, 0, 0);
    step('0, '0, EN, 9'h011, 1, 0);
    chk(irq_vec == 4'd0 && irq_level == 2'd3, "R4 highest preempts", int'(irq_level), 3);
    step('0, '0, EN, 9'h011, 0, 0);
    chk(svc_level == 2'd3, "R7 nested push", int'(svc_level), 3);
    step('0, '0, EN, 9'h011, 0, 1);
    step('0, '0, EN, 9'h011, 0, 1);
    chk(svc_level == 2'd2, "R8 pop to previous level", int'(svc_level), 2);
    step('0, '0, EN, '0, 0, 1);
    chk(svc_level == 2'd0 && irq_vec == 4'd2, "R8 pop to empty", int'(svc_level), 0);
    step('0, '0, EN, '0, 1, 0);
    chk(svc_level == 2'd0, "R8 return on empty ignored", int'(svc_level), 0);
    step('0, '0, EN, '0, 0, 0);
    chk(svc_level == 2'd1, "R7 low level pushed", int'(svc_level), 1);
    chk(src_flag[2] == 1'b1, "R2 shared flag kept", int'(src_flag[2]), 1);
    step('0, 14'h0004, EN, '0, 0, 1);
    step('0, '0, EN, '0, 0, 0);
    chk(src_flag[2] == 1'b0, "R1 software clear", int'(src_flag[2]), 0);
    step(14'h0200, '0, EN & ~9'h040, '0, 0, 0);
    step('0, '0, EN & ~9'h040, '0, 0, 0);
    chk(irq_valid == 1'b0, "R3 disabled not offered", int'(irq_valid), 0);
    chk(src_flag[9] == 1'b1, "R3 disabled flag kept", int'(src_flag[9]), 1);
    step('0, '0, EN, '0, 0, 0);
    chk(irq_valid && irq_vec == 4'd6, "R3 enabled offered", int'(irq_vec), 6);
    step('0, '0, EN, '0, 0, 0);
    chk(irq_valid && svc_level == 2'd0 && ack_vec == '0, "R9 stalled offer holds", int'(svc_level), 0);
    step(14'h0002, 14'h0002, EN, '0, 0, 0);
    step('0, '0, EN, '0, 0, 0);
    chk(src_flag[1] == 1'b1, "R1 set wins over clear", int'(src_flag[1]), 1);

    r_en = EN; r_pri = '0;
    for (int n = 0; n < 3000; n++) begin
      if (n % 64 == 0) begin
        r_en  = EN & ~(9'($urandom) & 9'($urandom) & 9'($urandom));
        r_pri = 9'($urandom);
      end
      s = '0; c = '0;
      for (int i = 0; i < 14; i++) begin
        if ($urandom_range(15) == 0) s[i] = 1'b1;
        if ($urandom_range(19) == 0) c[i] = 1'b1;
      end
      step(s, c, r_en, r_pri, $urandom_range(1) == 1, $urandom_range(6) == 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule